// File: doc/BRIEF.md
# SMBus Host Control and Status Register Block

This block is the software-facing side of an SMBus master. It holds a byte-wide status register and a byte-wide control register on a simple register bus. A write that sets the start bit becomes a single-cycle launch pulse toward the bit-level engine. The pulse carries the command selector and the packet-error-check choice. The engine's completion report clears the busy flag and raises a completion flag. That flag drives the interrupt line only when the interrupt enable is set.

Software polls the completion flag whether or not interrupts are enabled, and acknowledges it by writing 1 to it. For block reads, software sets a last-byte request that tells the engine to answer the next received byte with NACK. An external timeout status can pin that request high. Reading the control register also resets the byte pointer of the 32-entry block buffer, which is kept outside this block.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset both registers read 00h, and launch, interrupt, NACK request and pointer clear are all 0.
- R2: A control write (offset 02h) with bit 6 set, made while idle, produces a launch pulse exactly one cycle long in the next cycle. The command output then equals bits 4:2 of that write, and bit 6 always reads 0.
- R3: Status bit 0 (busy) reads 1 from the cycle after the launch pulse. It returns to 0 in the cycle after the engine reports completion while busy.
- R4: A start write made while busy is 1, or while the launch pulse is out, gives no launch pulse.
- R5: Status bit 1 (completion) is set by a completion report while busy, whatever the interrupt enable (control bit 0) holds.
- R6: Writing a status byte with bit 1 set clears the completion flag. A 0 in that bit has no effect. A completion report in the same cycle wins over the clear.
- R7: The interrupt output is 1 exactly when the completion flag and the interrupt enable are both 1.
- R8: Control bit 5 (last byte) is write-only and reads 0. Its stored value drives the NACK request, which clears when the engine reports completion.
- R9: While the timeout input is high, the NACK request is 1. Writes of 0 to bit 5 and completion reports do not clear it, and it stays 1 after the timeout falls until software writes 0.
- R10: A read of the control register pulses the pointer-clear output for one cycle in the next cycle. A status read or a control write does not.
- R11: Control bit 7 (PEC enable) reads back as written. The launched PEC flag is the value bit 7 held before the start write, not the value carried by it.
- R12: Control bits 4:2 (command field) and bit 0 read back as written. Bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect only; data is always driven) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| eng_launch | output | 1 | One-cycle command launch to the engine |
| eng_cmd | output | CMD_W | Command selector captured at launch |
| eng_pec | output | 1 | PEC phase requested for the launched command |
| eng_done | input | 1 | Engine reports command termination |
| eng_nack_last | output | 1 | Answer the next received byte with NACK |
| buf_ptr_clr | output | 1 | Reset the block-buffer byte pointer |
| tmo_hold | input | 1 | External timeout status forcing last byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is a completion report that lands in the same cycle as a software clear of the completion flag. It can only happen while a command is in flight, so the stimulus first launches a command, waits out the busy delay, then drives the acknowledge write and the completion pulse together. It then checks that the interrupt is still asserted. The timeout case is similar: the launch, completion and later clear all run with the timeout high and then low, to show that the NACK request survives each of them.

// File: rtl/smbus_host_regs.sv
module smbus_host_regs #(
  parameter int ADDR_W  = 8,
  parameter int CMD_W   = 3,
  parameter logic [ADDR_W-1:0] STS_OFS = 'h00,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              eng_launch,
  output logic [CMD_W-1:0]  eng_cmd,
  output logic              eng_pec,
  input  logic              eng_done,
  output logic              eng_nack_last,
  output logic              buf_ptr_clr,
  input  logic              tmo_hold,
  output logic              irq
);
  localparam int CMD_LSB = 2;
  localparam int B_IEN   = 0;
  localparam int B_LAST  = 5;
  localparam int B_START = 6;
  localparam int B_PEC   = 7;

  logic             busy, cmp_flag, ien, last_q, pec_en;
  logic [CMD_W-1:0] cmd_q;

  wire sts_hit  = reg_addr == STS_OFS;
  wire ctl_hit  = reg_addr == CTL_OFS;
  wire ctl_wr   = reg_wr && ctl_hit;
  wire sts_wr   = reg_wr && sts_hit;
  wire ctl_rd   = reg_rd && ctl_hit;
  wire done_ev  = eng_done && busy;
  wire start_ok = ctl_wr && reg_wdata[B_START] && !busy && !eng_launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cmp_flag    <= 1'b0;
      ien         <= 1'b0;
      last_q      <= 1'b0;
      pec_en      <= 1'b0;
      cmd_q       <= '0;
      eng_launch  <= 1'b0;
      eng_cmd     <= '0;
      eng_pec     <= 1'b0;
      buf_ptr_clr <= 1'b0;
    end else begin
      eng_launch  <= start_ok;
      buf_ptr_clr <= ctl_rd;
      if (start_ok) begin
        eng_cmd <= reg_wdata[CMD_LSB +: CMD_W];
        eng_pec <= pec_en;
      end
      if (done_ev)         busy <= 1'b0;
      else if (eng_launch) busy <= 1'b1;
      if (done_ev)                    cmp_flag <= 1'b1;
      else if (sts_wr && reg_wdata[1]) cmp_flag <= 1'b0;
      if (ctl_wr) begin
        ien    <= reg_wdata[B_IEN];
        pec_en <= reg_wdata[B_PEC];
        cmd_q  <= reg_wdata[CMD_LSB +: CMD_W];
      end
      if (tmo_hold)     last_q <= 1'b1;
      else if (ctl_wr)  last_q <= reg_wdata[B_LAST];
      else if (done_ev) last_q <= 1'b0;
    end
  end

  assign irq           = cmp_flag && ien;
  assign eng_nack_last = last_q;

  always_comb begin
    reg_rdata = '0;
    if (sts_hit) begin
      reg_rdata[0] = busy;
      reg_rdata[1] = cmp_flag;
    end else if (ctl_hit) begin
      reg_rdata[B_IEN]               = ien;
      reg_rdata[CMD_LSB +: CMD_W]    = cmd_q;
      reg_rdata[B_PEC]               = pec_en;
    end
  end

  assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_launch |=> !eng_launch);
  assert_busy_after_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_launch |=> busy);
  assert_busy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done |=> !busy);
  assert_no_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && ctl_hit |=> !eng_launch);
  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done |=> cmp_flag);
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && reg_wdata[1] && !(busy && eng_done) |=> !irq);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien && cmp_flag);
  assert_tmo_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hold |=> eng_nack_last);
  assert_ptr_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> buf_ptr_clr);
endmodule

// File: tb/smbus_host_regs_bench.sv
module smbus_host_regs_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, eng_done = 1'b0, tmo_hold = 1'b0;
  logic [7:0] reg_rdata;
  logic [2:0] eng_cmd;
  logic       eng_launch, eng_pec, eng_nack_last, buf_ptr_clr, irq;
  int         n_chk = 0, n_bad = 0;
  bit         ended = 1'b0;

  always #4 clk = ~clk;

  smbus_host_regs u_smbus_host_regs (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .eng_launch, .eng_cmd, .eng_pec, .eng_done, .eng_nack_last,
    .buf_ptr_clr, .tmo_hold, .irq
  );

  // {wr,rd} addr wdata {done,tmo} exp_rdata {launch,irq,nack,ptr_clr}
  localparam int NV = 37;
  localparam logic [31:0] VEC [NV] = '{
    {2'b01,8'h00,8'h00,2'b00,8'h00,4'b0000}, // R1 idle status
    {2'b10,8'h02,8'h01,2'b00,8'h00,4'b0000}, // R12 enable irq
    {2'b01,8'h02,8'h00,2'b00,8'h01,4'b0001}, // R10 ctl read clears ptr
    {2'b10,8'h02,8'h4D,2'b00,8'h01,4'b1000}, // R2 start cmd 3
    {2'b10,8'h02,8'h4D,2'b00,8'h0D,4'b0000}, // R4 start during pulse
    {2'b01,8'h00,8'h00,2'b00,8'h01,4'b0000}, // R3 busy, R10 status read
    {2'b10,8'h02,8'h4D,2'b00,8'h0D,4'b0000}, // R4 start while busy
    {2'b01,8'h00,8'h00,2'b10,8'h01,4'b0100}, // R5 done
    {2'b01,8'h00,8'h00,2'b00,8'h02,4'b0100}, // R3 busy clear
    {2'b10,8'h00,8'h00,2'b00,8'h02,4'b0100}, // R6 write 0 no effect
    {2'b10,8'h00,8'h02,2'b00,8'h02,4'b0000}, // R6 W1C
    {2'b01,8'h00,8'h00,2'b00,8'h00,4'b0000}, // R6 cleared
    {2'b10,8'h02,8'h4C,2'b00,8'h0D,4'b1000}, // R2 start, irq off
    {2'b00,8'h00,8'h00,2'b00,8'h00,4'b0000}, // R3 busy one cycle later
    {2'b00,8'h00,8'h00,2'b10,8'h01,4'b0000}, // R5 done w/o enable
    {2'b00,8'h00,8'h00,2'b00,8'h02,4'b0000}, // R5 flag polled
    {2'b10,8'h02,8'h01,2'b00,8'h0C,4'b0100}, // R7 enable raises irq
    {2'b10,8'h00,8'h02,2'b00,8'h02,4'b0000}, // R7 clear
    {2'b10,8'h02,8'h21,2'b00,8'h01,4'b0010}, // R8 set last
    {2'b01,8'h02,8'h00,2'b00,8'h01,4'b0011}, // R8 last reads 0
    {2'b10,8'h02,8'h61,2'b00,8'h01,4'b1010}, // R8 block read start
    {2'b00,8'h00,8'h00,2'b00,8'h00,4'b0010},
    {2'b00,8'h00,8'h00,2'b10,8'h01,4'b0100}, // R8 cleared by done
    {2'b10,8'h00,8'h02,2'b00,8'h02,4'b0000},
    {2'b00,8'h00,8'h00,2'b01,8'h00,4'b0010}, // R9 timeout forces
    {2'b10,8'h02,8'h01,2'b01,8'h01,4'b0010}, // R9 write 0 ignored
    {2'b10,8'h02,8'h41,2'b01,8'h01,4'b1010},
    {2'b00,8'h00,8'h00,2'b01,8'h00,4'b0010},
    {2'b00,8'h00,8'h00,2'b11,8'h01,4'b0110}, // R9 done does not clear
    {2'b00,8'h00,8'h00,2'b00,8'h02,4'b0110}, // R9 held after timeout
    {2'b10,8'h02,8'h01,2'b00,8'h01,4'b0100}, // R9 software clears
    {2'b10,8'h00,8'h02,2'b00,8'h02,4'b0000},
    {2'b10,8'h02,8'h41,2'b00,8'h01,4'b1000},
    {2'b00,8'h00,8'h00,2'b00,8'h00,4'b0000},
    {2'b10,8'h00,8'h02,2'b10,8'h01,4'b0100}, // R6 done beats clear
    {2'b00,8'h00,8'h00,2'b00,8'h02,4'b0100},
    {2'b10,8'h00,8'h02,2'b00,8'h02,4'b0000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] wr_rd, input logic [7:0] a, input logic [7:0] d,
                       input logic [1:0] dn_to);
    {reg_wr, reg_rd} = wr_rd;
    reg_addr = a;
    reg_wdata = d;
    {eng_done, tmo_hold} = dn_to;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_rdata == 8'h00, "R1", reg_rdata, 0);
    check({eng_launch, irq, eng_nack_last, buf_ptr_clr} == 4'b0, "R1",
          {eng_launch, irq, eng_nack_last, buf_ptr_clr}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31:30], VEC[i][29:22], VEC[i][21:14], VEC[i][13:12]);
      #1;
      check(reg_rdata == VEC[i][11:4], $sformatf("R%0d vec %0d rdata", 12, i),
            reg_rdata, VEC[i][11:4]);
      @(negedge clk);
      check({eng_launch, irq, eng_nack_last, buf_ptr_clr} == VEC[i][3:0],
            $sformatf("vec %0d outputs", i),
            {eng_launch, irq, eng_nack_last, buf_ptr_clr}, VEC[i][3:0]);
    end
    // R11 PEC sampled from value held before the start write
    drive(2'b10, 8'h02, 8'h81, 2'b00); @(negedge clk);
    drive(2'b10, 8'h02, 8'h41, 2'b00); @(negedge clk);
    check(eng_launch && eng_pec && eng_cmd == 3'd0, "R11 pec=1 launch",
          {eng_launch, eng_pec, eng_cmd}, 5'b11000);
    drive(2'b00, 8'h02, 8'h00, 2'b00); #1;
    check(reg_rdata == 8'h01, "R11 pec cleared by write", reg_rdata, 8'h01);
    @(negedge clk);
    drive(2'b00, 8'h00, 8'h00, 2'b10); @(negedge clk);
    drive(2'b10, 8'h00, 8'h02, 2'b00); @(negedge clk);
    drive(2'b10, 8'h02, 8'hD5, 2'b00); @(negedge clk);
    check(eng_launch && !eng_pec && eng_cmd == 3'd5, "R11 R2 pec=0 cmd=5",
          {eng_launch, eng_pec, eng_cmd}, 5'b10101);
    drive(2'b00, 8'h02, 8'h00, 2'b00); #1;
    check(reg_rdata == 8'h95, "R11 R12 readback", reg_rdata, 8'h95);
    @(negedge clk);
    // R1 reset while busy with completion pending
    drive(2'b00, 8'h00, 8'h00, 2'b00); #1;
    check(reg_rdata == 8'h01, "R3 busy before reset", reg_rdata, 8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    check(reg_rdata == 8'h00 && !eng_nack_last && !irq && !eng_launch, "R1 mid-run reset",
          reg_rdata, 0);
    reg_addr = 8'h02; #1;
    check(reg_rdata == 8'h00, "R1 ctl after reset", reg_rdata, 0);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule